// File: doc/BRIEF.md
# Trap Privilege Stack Controller

This block holds the processor's current privilege level and interrupt-enable bit, together with two saved copies of that pair. Together they form a three-level stack inside one status word. When a trap is taken, the stack shifts down one level. The core enters the highest privilege with interrupts off, the next fetch address is formed from a vector base and the privilege that was active before the trap, and the cause value is latched. A trap-return shifts the stack up one level. The deepest level is refilled with user privilege and interrupts enabled.

Software may also write the status word. The privilege fields and the address-translation mode field only accept legal codes; an illegal code leaves the stored field unchanged. A summary bit reports when the floating-point state field or the extension state field holds its dirty code. All state sits in registers, and the outputs are read straight from them.

Status word layout, for an XLEN-bit word, bit positions from 0:
- Bit 0: current enable. Bits 2:1: current privilege.
- Bit 3: level-1 enable. Bits 5:4: level-1 privilege.
- Bit 6: level-2 enable. Bits 8:7: level-2 privilege.
- Bit 9: modify-privilege.
- Bits 11:10: floating-point state.
- Bits 13:12: extension state.
- Bits 16:14: translation mode.
- Bit XLEN-1: dirty summary.

Privilege codes are U=0, S=1 and M=3. Code 2 is illegal.

Top module: `trap_priv_stack`

## Requirements
- R1: After reset the current privilege is M (3), both saved privileges are S (1), all three enables and the modify-privilege bit are 0, the cause is 0 and the PC is VEC_BASE+0x100 (status reads 0x96).
- R2: On a trap, level 2 takes level 1's pair and level 1 takes the current pair. The current privilege becomes M, and the current enable and the modify-privilege bit (bit 9) are cleared.
- R3: On a return, the current pair takes level 1's pair and level 1 takes level 2's pair. Level 2 then becomes privilege U with enable 1.
- R4: On a trap the PC becomes VEC_BASE + 0x40 × (the privilege code held before the trap).
- R5: Every trap loads the full XLEN-bit cause input into the cause register, including an interrupt cause whose most significant bit is set.
- R6: A software write to any of the three privilege fields takes effect only when the written code is U, S or M. Code 2 keeps the old value of that field. The enable bits are always written.
- R7: A software write to the translation mode field (bits 16:14) takes effect only for codes 0, 1 or 2. Any other code keeps the old mode.
- R8: Status bit XLEN-1 reads 1 exactly when bits 11:10 or bits 13:12 equal 2'b11. Software cannot write it directly.
- R9: If a trap arrives in the same cycle as a return or a software write, only the trap acts. A return in the same cycle as a write beats the write.
- R10: The PC changes only on a trap. Returns and writes leave it unchanged.
- R11: The modify-privilege bit and both state fields take any written value. Bits of the status word not listed in the layout read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_cause | input | XLEN | Cause value latched on a trap |
| ret_req | input | 1 | Return from trap this cycle |
| csr_we | input | 1 | Software write of the status word |
| csr_wdata | input | XLEN | Status write data |
| priv_o | output | 2 | Current privilege |
| ie_o | output | 1 | Current interrupt enable |
| pc_o | output | XLEN | Next PC after a trap or reset |
| status_o | output | XLEN | Status word readback |
| cause_o | output | XLEN | Latched trap cause |

## Verification
The bench walks a chain of traps and returns so that each stack level carries a distinct pattern. A design that shifted levels in the wrong direction, or refilled the wrong level, would show a mismatched status word. Traps are taken from U, S and M, which exercises all three vector offsets; a design that used the new privilege instead of the old one would always jump to the M offset.

Writes with privilege code 2 and translation modes above 2 check that illegal values leave the old fields in place rather than being stored or zeroed. Collisions of trap with return and of trap with write confirm that the trap alone acts. The bench also covers every combination of the two state fields that sets or clears the dirty summary, and a write that tries to set that bit directly.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_M = 2'd3
  } priv_e;

  typedef struct packed {
    logic [1:0] priv;
    logic       ie;
  } lvl_t;

  localparam int unsigned LEVELS   = 3;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned MPRV_BIT = 9;
  localparam int unsigned FS_LO    = 10;
  localparam int unsigned XS_LO    = 12;
  localparam int unsigned MODE_LO  = 14;
  localparam int unsigned MODE_W   = 3;

  function automatic logic priv_legal(input logic [1:0] p);
    return (p == PRV_U) || (p == PRV_S) || (p == PRV_M);
  endfunction

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return m <= 3'd2;
  endfunction
endpackage

// File: rtl/tps_wr_filter.sv
module tps_wr_filter
  import tps_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   wdata,
  input  lvl_t              cur_lvl [LEVELS],
  input  logic [MODE_W-1:0] cur_mode,
  output lvl_t              nxt_lvl [LEVELS],
  output logic              nxt_mprv,
  output logic [1:0]        nxt_fs,
  output logic [1:0]        nxt_xs,
  output logic [MODE_W-1:0] nxt_mode
);
  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    logic [1:0] wp;
    assign wp = wdata[LVL_W*i+2 -: 2];
    assign nxt_lvl[i].ie   = wdata[LVL_W*i];
    assign nxt_lvl[i].priv = priv_legal(wp) ? wp : cur_lvl[i].priv;
  end

  logic [MODE_W-1:0] wm;
  assign wm       = wdata[MODE_LO +: MODE_W];
  assign nxt_mode = mode_legal(wm) ? wm : cur_mode;
  assign nxt_mprv = wdata[MPRV_BIT];
  assign nxt_fs   = wdata[FS_LO +: 2];
  assign nxt_xs   = wdata[XS_LO +: 2];
endmodule

// File: rtl/tps_stack.sv
module tps_stack
  import tps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic load,
  input  lvl_t load_lvl [LEVELS],
  output lvl_t lvl      [LEVELS]
);
  lvl_t lvl_q [LEVELS];

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    lvl_t rst_val, push_val, pop_val;
    if (i == 0) begin : g_top
      assign rst_val  = '{priv: PRV_M, ie: 1'b0};
      assign push_val = '{priv: PRV_M, ie: 1'b0};
    end else begin : g_low
      assign rst_val  = '{priv: PRV_S, ie: 1'b0};
      assign push_val = lvl_q[i-1];
    end
    if (i == LEVELS-1) begin : g_bot
      assign pop_val = '{priv: PRV_U, ie: 1'b1};
    end else begin : g_up
      assign pop_val = lvl_q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)       lvl_q[i] <= rst_val;
      else if (push) lvl_q[i] <= push_val;
      else if (pop)  lvl_q[i] <= pop_val;
      else if (load) lvl_q[i] <= load_lvl[i];
    end
    assign lvl[i] = lvl_q[i];
  end

  // R2: a push always leaves the top level at M with interrupts off
  a_r2_push_top: assert property (@(posedge clk) disable iff (rst)
    push |=> (lvl_q[0].priv == PRV_M) && !lvl_q[0].ie);
  // R3: a pop without a push refills the bottom level with U and enable set
  a_r3_pop_fill: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> (lvl_q[LEVELS-1].priv == PRV_U) && lvl_q[LEVELS-1].ie);
  // R6: no level ever holds the illegal privilege code
  a_r6_no_bad_priv: assert property (@(posedge clk) disable iff (rst)
    lvl_q[0].priv != 2'd2 && lvl_q[1].priv != 2'd2 && lvl_q[2].priv != 2'd2);
endmodule

// File: rtl/tps_vector.sv
module tps_vector
  import tps_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap,
  input  logic [1:0]      prev_priv,
  input  logic [XLEN-1:0] cause_in,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] cause
);
  localparam logic [XLEN-1:0] RST_PC = VEC_BASE + XLEN'('h100);

  logic [XLEN-1:0] pc_q, cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RST_PC;
      cause_q <= '0;
    end else if (trap) begin
      pc_q    <= VEC_BASE + (XLEN'(prev_priv) << 6);
      cause_q <= cause_in;
    end
  end

  assign pc    = pc_q;
  assign cause = cause_q;

  // R4: a trap lands on one of the three privilege-dependent vectors
  a_r4_vec_target: assert property (@(posedge clk) disable iff (rst)
    trap |=> (pc_q == VEC_BASE) || (pc_q == VEC_BASE + XLEN'('h40))
             || (pc_q == VEC_BASE + XLEN'('hC0)));
  // R10: the PC holds whenever no trap is taken
  a_r10_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !trap |=> $stable(pc_q));
endmodule

// File: rtl/trap_priv_stack.sv
module trap_priv_stack
  import tps_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_cause,
  input  logic            ret_req,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [1:0]      priv_o,
  output logic            ie_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] cause_o
);
  lvl_t              lvl     [LEVELS];
  lvl_t              wr_lvl  [LEVELS];
  logic              wr_mprv;
  logic [1:0]        wr_fs, wr_xs;
  logic [MODE_W-1:0] wr_mode;
  logic              mprv_q;
  logic [1:0]        fs_q, xs_q;
  logic [MODE_W-1:0] mode_q;
  logic              do_pop, do_wr;

  // R9: trap beats return, return beats a software write
  assign do_pop = ret_req && !trap_req;
  assign do_wr  = csr_we && !trap_req && !ret_req;

  tps_wr_filter #(.XLEN(XLEN)) u_filter (
    .wdata    (csr_wdata),
    .cur_lvl  (lvl),
    .cur_mode (mode_q),
    .nxt_lvl  (wr_lvl),
    .nxt_mprv (wr_mprv),
    .nxt_fs   (wr_fs),
    .nxt_xs   (wr_xs),
    .nxt_mode (wr_mode)
  );

  tps_stack u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (trap_req),
    .pop      (do_pop),
    .load     (do_wr),
    .load_lvl (wr_lvl),
    .lvl      (lvl)
  );

  tps_vector #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .trap      (trap_req),
    .prev_priv (lvl[0].priv),
    .cause_in  (trap_cause),
    .pc        (pc_o),
    .cause     (cause_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mprv_q <= 1'b0;
      fs_q   <= '0;
      xs_q   <= '0;
      mode_q <= '0;
    end else if (trap_req) begin
      mprv_q <= 1'b0;
    end else if (do_wr) begin
      mprv_q <= wr_mprv;
      fs_q   <= wr_fs;
      xs_q   <= wr_xs;
      mode_q <= wr_mode;
    end
  end

  always_comb begin
    status_o = '0;
    for (int i = 0; i < LEVELS; i++) begin
      status_o[LVL_W*i]        = lvl[i].ie;
      status_o[LVL_W*i+1 +: 2] = lvl[i].priv;
    end
    status_o[MPRV_BIT]          = mprv_q;
    status_o[FS_LO +: 2]        = fs_q;
    status_o[XS_LO +: 2]        = xs_q;
    status_o[MODE_LO +: MODE_W] = mode_q;
    status_o[XLEN-1]            = (&fs_q) || (&xs_q);
  end

  assign priv_o = lvl[0].priv;
  assign ie_o   = lvl[0].ie;

  // R5: the cause register follows the cause presented with each trap
  a_r5_cause_load: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> cause_o == $past(trap_cause));
  // R2: the modify-privilege bit is clear after every trap
  a_r2_mprv_clear: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> !status_o[MPRV_BIT]);
  // R7: the translation mode never holds an illegal code
  a_r7_mode_legal: assert property (@(posedge clk) disable iff (rst)
    status_o[MODE_LO +: MODE_W] <= 3'd2);
  // R9: a return in the trap cycle does not stop the core entering M
  a_r9_trap_wins: assert property (@(posedge clk) disable iff (rst)
    (trap_req && ret_req) |=> priv_o == PRV_M);
endmodule

// File: tb/tb_trap_priv_stack.sv
module tb_trap_priv_stack;
  localparam int  XLEN = 32;
  localparam time TCLK = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic            trap_req, ret_req, csr_we;
  logic [XLEN-1:0] trap_cause, csr_wdata;
  logic [1:0]      priv_o;
  logic            ie_o;
  logic [XLEN-1:0] pc_o, status_o, cause_o;

  int  checks = 0, errors = 0;
  logic done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  trap_priv_stack #(.XLEN(XLEN), .VEC_BASE(32'h100)) dut (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_cause(trap_cause),
    .ret_req(ret_req), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .priv_o(priv_o), .ie_o(ie_o), .pc_o(pc_o), .status_o(status_o),
    .cause_o(cause_o)
  );

  // op: 0 idle, 1 trap, 2 return, 3 write, 4 trap+return, 5 trap+write
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [31:0] cause;
    logic [31:0] st;
    logic [31:0] pc;
    logic [31:0] ecause;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TAB [NV] = '{
    '{3'd2, 32'h0,        32'h0,        32'h52,       32'h200, 32'h0,        8'd3},  // R3 pop from reset
    '{3'd1, 32'h0,        32'h3,        32'h96,       32'h140, 32'h3,        8'd4},  // R4 trap from S
    '{3'd3, 32'h399,      32'h0,        32'h399,      32'h140, 32'h3,        8'd11}, // R11 write all legal
    '{3'd1, 32'h0,        32'h5,        32'hCE,       32'h100, 32'h5,        8'd2},  // R2 trap from U
    '{3'd1, 32'h0,        32'h80000007, 32'h76,       32'h1C0, 32'h80000007, 8'd5},  // R5 interrupt cause
    '{3'd2, 32'h0,        32'h0,        32'h4E,       32'h1C0, 32'h80000007, 8'd10}, // R10 pc holds
    '{3'd2, 32'h0,        32'h0,        32'h49,       32'h1C0, 32'h80000007, 8'd3},  // R3 second pop
    '{3'd3, 32'h114,      32'h0,        32'h10,       32'h1C0, 32'h80000007, 8'd6},  // R6 illegal priv
    '{3'd4, 32'h0,        32'h2,        32'h86,       32'h100, 32'h2,        8'd9},  // R9 trap+return
    '{3'd3, 32'hC86,      32'h0,        32'h80000C86, 32'h100, 32'h2,        8'd8},  // R8 fp dirty
    '{3'd3, 32'h3486,     32'h0,        32'h80003486, 32'h100, 32'h2,        8'd8},  // R8 ext dirty
    '{3'd3, 32'h2886,     32'h0,        32'h2886,     32'h100, 32'h2,        8'd8},  // R8 not dirty
    '{3'd3, 32'h8086,     32'h0,        32'h8086,     32'h100, 32'h2,        8'd7},  // R7 legal mode
    '{3'd3, 32'h14086,    32'h0,        32'h8086,     32'h100, 32'h2,        8'd7},  // R7 illegal mode
    '{3'd3, 32'h80040086, 32'h0,        32'h86,       32'h100, 32'h2,        8'd11}, // R11 unlisted bits
    '{3'd5, 32'hFFFFFFFF, 32'h9,        32'h36,       32'h1C0, 32'h9,        8'd9}   // R9 trap+write
  };

  task automatic chk(input string what, input int req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    trap_req = 1'b0; ret_req = 1'b0; csr_we = 1'b0;
    trap_cause = '0; csr_wdata = '0;
  endtask

  task automatic check_reset_state();
    // R1: reset values
    chk("reset status", 1, status_o, 32'h96);
    chk("reset pc",     1, pc_o,     32'h200);
    chk("reset cause",  1, cause_o,  32'h0);
    chk("reset priv/ie", 1, {29'd0, priv_o, ie_o}, {29'd0, 2'd3, 1'b0});
  endtask

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TAB[k];
      idle_inputs();
      trap_req   = (v.op == 3'd1) || (v.op == 3'd4) || (v.op == 3'd5);
      ret_req    = (v.op == 3'd2) || (v.op == 3'd4);
      csr_we     = (v.op == 3'd3) || (v.op == 3'd5);
      trap_cause = v.cause;
      csr_wdata  = v.data;
      @(negedge clk);
      chk($sformatf("row %0d status", k), int'(v.req), status_o, v.st);
      chk($sformatf("row %0d pc", k),     int'(v.req), pc_o,     v.pc);
      chk($sformatf("row %0d cause", k),  int'(v.req), cause_o,  v.ecause);
      chk($sformatf("row %0d priv/ie", k), int'(v.req),
          {29'd0, priv_o, ie_o}, {29'd0, v.st[2:1], v.st[0]});
    end

    // R10: idle cycles leave everything unchanged
    idle_inputs();
    repeat (2) @(negedge clk);
    chk("idle status", 10, status_o, 32'h36);
    chk("idle pc",     10, pc_o,     32'h1C0);

    // R1: reset in mid-run restores the reset state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule